// File: doc/BRIEF.md
# Read-After-Write Hazard Interlock and Forwarding Unit

This block resolves read-after-write data hazards for a five-stage in-order pipeline whose register-file-like state memory is read in stage 2 and written in stage 5. Each cycle it compares the stage-2 read request against the pending writes carried by the instructions in stages 3, 4 and 5. A match is settled by forwarding the pending write data where that is allowed. Where it is not allowed, the unit holds the front of the pipeline and injects a bubble.

Each writer source carries a per-source forward-inhibit flag. A typical use is a load whose data is not ready yet. A source with this flag set is never picked by the forwarding mux, and any match on it is settled by a stall instead. When a younger source is forwarded, older matches behind it are covered by that forward, because the younger write overrides them. A parameter can turn forwarding off entirely, in which case every match stalls. The unit is purely combinational, so its stall, bubble and read-data outputs answer in the same cycle as the request.

Top module: `hz_interlock_bypass`

## Requirements
- R1: A source k (bit k of the writer vectors, k=0 is stage 3, k=1 stage 4, k=2 stage 5) matches only when `rd_en_i`, `wr_en_i[k]` are both 1 and `wr_addr_i[k]` equals `rd_addr_i`; a deasserted read enable, a deasserted write enable or a differing address gives no match.
- R2: With forwarding enabled, `rd_data_o` takes the write data of the lowest-numbered (youngest) matching source whose `no_byp_i` bit is 0, in preference to all older matching sources.
- R3: A matching source whose `no_byp_i` bit is 1, and which has no younger forwardable match ahead of it, raises a stall and a bubble.
- R4: A forwarded match also covers all older matches, including inhibited ones; such a cycle shows no stall and no bubble.
- R5: With no match (including the reset state, all inputs 0), `rd_data_o` equals `mem_rdata_i` and every stall and bubble bit is 0.
- R6: `stall_o` bit s stands for stage s+1 and is the OR of the unresolved hazards in that stage and all later stages; hazards belong to stage 2, so bits 0 and 1 are always equal and bits 2 and up stay 0.
- R7: `bubble_o` bit s is set when stage s+1 has an unresolved hazard and no later stage has one; at most one bit is set, and bit 1 equals `stall_o` bit 1.
- R8: With `BYPASS_EN` = 0, every match stalls and `rd_data_o` always equals `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_en_i | input | 1 | Stage-2 read request valid |
| rd_addr_i | input | ADDR_W | Stage-2 read address |
| mem_rdata_i | input | DATA_W | Data read from the state memory |
| wr_en_i | input | NUM_WR | Write valid for each writer stage (bit 0 = stage 3) |
| wr_addr_i | input | NUM_WR x ADDR_W | Write address for each writer stage |
| wr_data_i | input | NUM_WR x DATA_W | Write data for each writer stage |
| no_byp_i | input | NUM_WR | Forward inhibit for each writer stage |
| rd_data_o | output | DATA_W | Operand after forwarding |
| stall_o | output | NUM_WR+2 | Hold request per stage (bit 0 = stage 1) |
| bubble_o | output | NUM_WR+2 | Bubble insert per stage (bit 0 = stage 1) |

## Verification
The bench builds two copies of the unit from the same stimulus: one with the default parameters (three writer stages, forwarding on) and one with `BYPASS_EN` = 0. Comparing them shows that the forward-inhibit and shadowing rules only matter when forwarding is present. Random traffic draws addresses from four values only. This makes double and triple matches with mixed inhibit flags common, which brings the priority order and the older-match coverage of R2 and R4 within reach.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // pipeline stage that owns the read port (stage numbers start at 1)
    localparam int unsigned HZ_RD_STAGE = 2;

    // first stage that carries a pending write
    localparam int unsigned HZ_FIRST_WR_STAGE = 3;

    // bit index of a stage inside a per-stage vector
    function automatic int unsigned stage_bit(input int unsigned stage);
        return stage - 1;
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int unsigned NUM_WR = 3,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_WR-1:0]              wr_en,
    input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
    output logic [NUM_WR-1:0]              hit
);

    // one comparator per writer stage
    for (genvar k = 0; k < NUM_WR; k++) begin : g_cmp
        assign hit[k] = rd_en & wr_en[k] & (wr_addr[k] == rd_addr);
    end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
    parameter int unsigned NUM_WR    = 3,
    parameter int unsigned DATA_W    = 32,
    parameter bit          BYPASS_EN = 1'b1
) (
    input  logic [NUM_WR-1:0]              hit,
    input  logic [NUM_WR-1:0]              no_byp,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]              mem_rdata,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           pending
);

    logic [NUM_WR-1:0] elig;
    logic [NUM_WR-1:0] sel;
    logic [NUM_WR-1:0] younger;
    logic [DATA_W-1:0] fwd_data;

    if (BYPASS_EN) begin : g_byp
        assign elig = hit & ~no_byp;
    end else begin : g_nobyp
        logic unused_no_byp;
        assign unused_no_byp = ^no_byp;
        assign elig          = '0;
    end

    // lowest set bit = youngest forwardable writer
    assign sel     = elig & (~elig + 1'b1);
    // bits strictly below the pick; all ones when nothing was picked
    assign younger = sel - 1'b1;
    // hits younger than the pick cannot be covered by it
    assign pending = |(hit & younger);

    always_comb begin
        fwd_data = '0;
        for (int k = 0; k < NUM_WR; k++) begin
            fwd_data = fwd_data | (wr_data[k] & {DATA_W{sel[k]}});
        end
    end

    assign rd_data = (|sel) ? fwd_data : mem_rdata;

endmodule

// File: rtl/hz_stall_gen.sv
module hz_stall_gen #(
    parameter int unsigned NUM_STG = 5
) (
    input  logic [NUM_STG-1:0] haz,
    output logic [NUM_STG-1:0] stall,
    output logic [NUM_STG-1:0] bubble
);

    logic [NUM_STG-1:0] later;

    // later[s]: some stage after s+1 has an unresolved hazard
    always_comb begin
        later = '0;
        for (int s = NUM_STG - 2; s >= 0; s--) begin
            later[s] = later[s+1] | haz[s+1];
        end
    end

    assign stall  = haz | later;
    assign bubble = haz & ~later;

endmodule

// File: rtl/hz_interlock_bypass.sv
module hz_interlock_bypass #(
    parameter int unsigned NUM_WR    = 3,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter bit          BYPASS_EN = 1'b1,
    localparam int unsigned NUM_STG  = NUM_WR + 2
) (
    input  logic                           rd_en_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    input  logic [DATA_W-1:0]              mem_rdata_i,
    input  logic [NUM_WR-1:0]              wr_en_i,
    input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
    input  logic [NUM_WR-1:0]              no_byp_i,
    output logic [DATA_W-1:0]              rd_data_o,
    output logic [NUM_STG-1:0]             stall_o,
    output logic [NUM_STG-1:0]             bubble_o
);

    localparam int unsigned RD_BIT = hz_pkg::stage_bit(hz_pkg::HZ_RD_STAGE);

    logic [NUM_WR-1:0]  hit;
    logic               pending;
    logic [NUM_STG-1:0] haz_stg;

    hz_match #(
        .NUM_WR (NUM_WR),
        .ADDR_W (ADDR_W)
    ) u_match (
        .rd_en   (rd_en_i),
        .rd_addr (rd_addr_i),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .hit     (hit)
    );

    hz_fwd_pick #(
        .NUM_WR    (NUM_WR),
        .DATA_W    (DATA_W),
        .BYPASS_EN (BYPASS_EN)
    ) u_pick (
        .hit       (hit),
        .no_byp    (no_byp_i),
        .wr_data   (wr_data_i),
        .mem_rdata (mem_rdata_i),
        .rd_data   (rd_data_o),
        .pending   (pending)
    );

    // every hazard of the read port is charged to the read stage
    always_comb begin
        haz_stg         = '0;
        haz_stg[RD_BIT] = pending;
    end

    hz_stall_gen #(
        .NUM_STG (NUM_STG)
    ) u_stall (
        .haz    (haz_stg),
        .stall  (stall_o),
        .bubble (bubble_o)
    );

endmodule

// File: rtl/hz_interlock_bypass_chk.sv
module hz_interlock_bypass_chk #(
    parameter int unsigned NUM_WR    = 3,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter bit          BYPASS_EN = 1'b1,
    localparam int unsigned NUM_STG  = NUM_WR + 2
) (
    input  logic                           rd_en_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    input  logic [DATA_W-1:0]              mem_rdata_i,
    input  logic [NUM_WR-1:0]              wr_en_i,
    input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
    input  logic [NUM_WR-1:0]              no_byp_i,
    input  logic [DATA_W-1:0]              rd_data_o,
    input  logic [NUM_STG-1:0]             stall_o,
    input  logic [NUM_STG-1:0]             bubble_o
);

    logic              any_m;
    logic              blk;
    logic              fw_found;
    logic [DATA_W-1:0] fw_d;

    // walk the writers from youngest to oldest
    always_comb begin
        any_m    = 1'b0;
        blk      = 1'b0;
        fw_found = 1'b0;
        fw_d     = '0;
        for (int k = 0; k < NUM_WR; k++) begin
            if (rd_en_i && wr_en_i[k] && (wr_addr_i[k] == rd_addr_i)) begin
                any_m = 1'b1;
                if (!fw_found) begin
                    if (no_byp_i[k] || !BYPASS_EN) begin
                        blk = 1'b1;
                    end else begin
                        fw_found = 1'b1;
                        fw_d     = wr_data_i[k];
                    end
                end
            end
        end
    end

    always_comb begin
        assert_front_pair_R6: assert (stall_o[0] == stall_o[1])
            else $error("stage 1 and stage 2 hold differ");
        assert_back_quiet_R6: assert (stall_o[NUM_STG-1:2] == '0)
            else $error("stage after read stage held");
        assert_bubble_single_R7: assert ($onehot0(bubble_o) && (bubble_o[1] == stall_o[1]))
            else $error("bubble vector inconsistent");
        assert_interlock_R3: assert (stall_o[1] == blk)
            else $error("hold does not match unresolved match");
        if (fw_found && !blk) begin
            assert_fwd_youngest_R2: assert (rd_data_o == fw_d)
                else $error("forwarded data not from youngest eligible writer");
        end
        if (!any_m) begin
            assert_pass_through_R5: assert ((rd_data_o == mem_rdata_i) && (stall_o == '0) && (bubble_o == '0))
                else $error("quiet cycle disturbed");
        end
        if (!BYPASS_EN) begin
            assert_no_fwd_R8: assert (rd_data_o == mem_rdata_i)
                else $error("data forwarded with forwarding off");
        end
    end

endmodule

bind hz_interlock_bypass hz_interlock_bypass_chk #(
    .NUM_WR    (NUM_WR),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BYPASS_EN (BYPASS_EN)
) u_chk (.*);

// File: tb/hz_interlock_bypass_tb.sv
module hz_interlock_bypass_tb;

    localparam int unsigned NW   = 3;
    localparam int unsigned AW   = 5;
    localparam int unsigned DW   = 16;
    localparam int unsigned NSTG = NW + 2;

    typedef struct {
        string          tag;
        logic [DW-1:0]  data;
        logic [NSTG-1:0] stall;
        logic [NSTG-1:0] bub;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                   ren;
    logic [AW-1:0]          raddr;
    logic [DW-1:0]          mem;
    logic [NW-1:0]          wen;
    logic [NW-1:0][AW-1:0]  waddr;
    logic [NW-1:0][DW-1:0]  wdata;
    logic [NW-1:0]          nb;

    logic [DW-1:0]   dat_on,  dat_off;
    logic [NSTG-1:0] stl_on,  stl_off;
    logic [NSTG-1:0] bub_on,  bub_off;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    exp_t q_on[$];
    exp_t q_off[$];

    hz_interlock_bypass #(.NUM_WR(NW), .ADDR_W(AW), .DATA_W(DW), .BYPASS_EN(1'b1)) u_dut (
        .rd_en_i(ren), .rd_addr_i(raddr), .mem_rdata_i(mem), .wr_en_i(wen),
        .wr_addr_i(waddr), .wr_data_i(wdata), .no_byp_i(nb),
        .rd_data_o(dat_on), .stall_o(stl_on), .bubble_o(bub_on)
    );

    hz_interlock_bypass #(.NUM_WR(NW), .ADDR_W(AW), .DATA_W(DW), .BYPASS_EN(1'b0)) u_dut_nobyp (
        .rd_en_i(ren), .rd_addr_i(raddr), .mem_rdata_i(mem), .wr_en_i(wen),
        .wr_addr_i(waddr), .wr_data_i(wdata), .no_byp_i(nb),
        .rd_data_o(dat_off), .stall_o(stl_off), .bubble_o(bub_off)
    );

    // reference: youngest eligible match forwards, an unforwardable match ahead of it holds
    function automatic exp_t model(input bit byp, input string tag);
        exp_t e;
        bit   picked = 1'b0;
        bit   hold   = 1'b0;
        e.tag  = tag;
        e.data = mem;
        for (int k = 0; k < NW; k++) begin
            if (ren && wen[k] && waddr[k] == raddr && !picked) begin
                if (byp && !nb[k]) begin
                    picked = 1'b1;
                    e.data = wdata[k];
                end else begin
                    hold = 1'b1;
                end
            end
        end
        e.stall = '0;
        e.bub   = '0;
        e.stall[0] = hold;
        e.stall[1] = hold;
        e.bub[1]   = hold;
        return e;
    endfunction

    task automatic push_exp(input string tag);
        q_on.push_back(model(1'b1, tag));
        q_off.push_back(model(1'b0, "R8"));
    endtask

    task automatic apply(input logic r, input logic [AW-1:0] ra, input logic [DW-1:0] m,
                         input logic [NW-1:0] we, input logic [NW-1:0][AW-1:0] wa,
                         input logic [NW-1:0][DW-1:0] wd, input logic [NW-1:0] n,
                         input string tag);
        @(posedge clk);
        #1;
        ren = r; raddr = ra; mem = m; wen = we; waddr = wa; wdata = wd; nb = n;
        push_exp(tag);
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare at the falling edge after each stimulus
    always @(negedge clk) begin
        if (q_on.size() > 0) begin
            exp_t a;
            exp_t b;
            a = q_on.pop_front();
            b = q_off.pop_front();
            chk(a.tag, "rd_data", 64'(dat_on), 64'(a.data));
            chk(a.tag, "stall",   64'(stl_on), 64'(a.stall));
            chk(a.tag, "bubble",  64'(bub_on), 64'(a.bub));
            chk(b.tag, "rd_data_nobyp", 64'(dat_off), 64'(b.data));
            chk(b.tag, "stall_nobyp",   64'(stl_off), 64'(b.stall));
            chk(b.tag, "bubble_nobyp",  64'(bub_off), 64'(b.bub));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0][DW-1:0] d;
        d[0] = 16'hA000; d[1] = 16'hB111; d[2] = 16'hC222;
        ren = 0; raddr = '0; mem = '0; wen = '0; waddr = '0; wdata = '0; nb = '0;
        repeat (3) @(posedge clk);
        // reset state: all quiet (R5)
        push_exp("R5");
        @(posedge clk);
        rst = 1'b0;

        // R1: no read enable, no write enable, address mismatch
        apply(1'b0, 5'd7, 16'h1234, 3'b111, {5'd7, 5'd7, 5'd7}, d, 3'b000, "R1");
        apply(1'b1, 5'd7, 16'h2345, 3'b000, {5'd7, 5'd7, 5'd7}, d, 3'b000, "R1");
        apply(1'b1, 5'd7, 16'h3456, 3'b111, {5'd6, 5'd5, 5'd4}, d, 3'b000, "R1");
        // R5: plain read
        apply(1'b1, 5'd9, 16'h4567, 3'b000, '0, d, 3'b111, "R5");
        // R2: priority of the youngest writer (packed index 2 is stage 5)
        apply(1'b1, 5'd3, 16'h5678, 3'b100, {5'd3, 5'd0, 5'd0}, d, 3'b000, "R2");
        apply(1'b1, 5'd3, 16'h5678, 3'b110, {5'd3, 5'd3, 5'd0}, d, 3'b000, "R2");
        apply(1'b1, 5'd3, 16'h5678, 3'b111, {5'd3, 5'd3, 5'd3}, d, 3'b000, "R2");
        // R3: inhibited youngest match holds; inhibited stage 4 ahead of stage 5 holds
        apply(1'b1, 5'd12, 16'h6789, 3'b001, {5'd0, 5'd0, 5'd12}, d, 3'b001, "R3");
        apply(1'b1, 5'd12, 16'h6789, 3'b110, {5'd12, 5'd12, 5'd0}, d, 3'b010, "R3");
        // R4: forwarded stage 3 covers inhibited stage 4 and 5
        apply(1'b1, 5'd20, 16'h789A, 3'b111, {5'd20, 5'd20, 5'd20}, d, 3'b110, "R4");
        // R6 / R7: hold and bubble shape
        apply(1'b1, 5'd31, 16'h89AB, 3'b100, {5'd31, 5'd0, 5'd0}, d, 3'b100, "R6");
        apply(1'b1, 5'd0,  16'h9ABC, 3'b011, {5'd1, 5'd0, 5'd0}, d, 3'b011, "R7");

        // random traffic over a small address space
        for (int i = 0; i < 400; i++) begin
            logic [NW-1:0][AW-1:0] wa;
            logic [NW-1:0][DW-1:0] wd;
            for (int k = 0; k < NW; k++) begin
                wa[k] = AW'($urandom_range(3));
                wd[k] = DW'($urandom);
            end
            apply(1'($urandom), AW'($urandom_range(3)), DW'($urandom),
                  NW'($urandom), wa, wd, NW'($urandom), "R2");
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule